// File: doc/BRIEF.md
# Audio Playback Sample FIFO with DMA Request

This block sits between a system bus and a digital-to-analog audio converter. Software, or a DMA engine, writes audio samples into a data port. The samples queue in a small FIFO. The block drains one queued sample each time the converter's sample-rate strobe arrives, and it presents that sample on a left and right output pair. While the FIFO has more free entries than a programmable trigger level, it raises a DMA request, so that a DMA engine can keep the queue topped up without interrupts.

All control goes through a 32-bit register bus with five word registers:

| Word address | Register |
|---|---|
| 0x00 | Global enable |
| 0x04 | Control |
| 0x08 | Status |
| 0x0C | Transmit data |
| 0x10 | Sample counter |

The control register holds several fields:

- a stored sample-rate code
- the DMA trigger level
- mono duplication
- 16- or 24-bit sample width
- a DMA request enable
- a playback run bit
- a self-clearing flush bit

The status register reports the free-entry count and two sticky error flags, underrun and overflow. The error flags are cleared by writing back the value that was read.

Top module: `dac_tx_fifo`

## Requirements
- R1: After reset, every register reads zero except status, whose bits 14:8 read the FIFO depth. `dmaReq`, `outLeft`, `outRight` and `outValid` are all low.
- R2: A write to the data port (0x0C) pushes one sample. When control bit 5 is 0 (16-bit mode), the stored 24-bit sample is write-data bits 15:0 followed by eight zero bits. When bit 5 is 1 (24-bit mode), the stored sample is write-data bits 23:0.
- R3: Samples leave in the order they were written. Status bits 14:8 read the depth minus the current occupancy. A write to the data port while the FIFO is full is dropped and sets sticky status bit 1 (overflow).
- R4: `dmaReq` is high exactly when control bit 4 is 1 and the free-entry count is greater than the 4-bit trigger level in control bits 11:8.
- R5: On a `sampleStrobe` cycle, one entry is consumed only if enable-register bit 31 and control bit 2 are both 1. If either bit is 0, the strobe consumes nothing and changes no output.
- R6: When control bit 6 (mono) is 1, a consumed sample appears on both `outLeft` and `outRight`. When bit 6 is 0 (stereo), consumed samples go alternately to `outLeft` and then `outRight`, starting with left after reset or a flush.
- R7: A strobe that would consume a sample while the FIFO is empty does three things: it drives both outputs to zero, sets sticky status bit 0 (underrun), and leaves the sample counter unchanged.
- R8: Writing 1 to a status flag bit clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R9: Writing control with bit 0 set empties the FIFO and returns the stereo slot to left. Control bit 0 always reads back 0.
- R10: The sample counter (0x10) increases by one for each consumed sample. A write to the counter presets it to the written value.
- R11: Control bits 31:29 store a sample-rate code that reads back unchanged, where code 0 stands for 48 kHz. Writing 0 to the whole control register drops `dmaReq` and stops draining.
- R12: `outValid` is high for exactly one cycle, in the cycle after each strobe that is acted on, and that includes underrun strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Byte address; bits ADDR_W-1:2 select the word |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data, combinational from `busAddr` |
| sampleStrobe | input | 1 | One-cycle pulse per output sample period |
| dmaReq | output | 1 | DMA request, high while free space exceeds the trigger level |
| outLeft | output | 24 | Left output sample |
| outRight | output | 24 | Right output sample |
| outValid | output | 1 | Pulses one cycle after each processed strobe |

## Verification
The bench builds the block with a depth of 8 entries, not the default 32. At that depth, every fill level from empty to full can be combined with every one of the 16 trigger codes. The bench checks the request output and the free-count field arithmetically for each of those combinations. The small depth also lets the bench reach a full FIFO and the overflow flag in a handful of writes, while the stereo ordering, underrun and counter checks run on short sequences.

// File: rtl/dac_fifo_pkg.sv
package dac_fifo_pkg;

  localparam int SAMPLE_W = 24;
  localparam int REG_W    = 32;

  // word indices on the register bus
  localparam int IDX_ENABLE = 0;
  localparam int IDX_CTRL   = 1;
  localparam int IDX_STATUS = 2;
  localparam int IDX_TXDATA = 3;
  localparam int IDX_COUNT  = 4;

  // control register bit positions
  localparam int CB_FLUSH  = 0;
  localparam int CB_RUN    = 2;
  localparam int CB_DMAEN  = 4;
  localparam int CB_WIDE   = 5;
  localparam int CB_MONO   = 6;
  localparam int CB_TRIG_L = 8;
  localparam int CB_RATE_L = 29;

  // status register bit positions
  localparam int SB_UNDER  = 0;
  localparam int SB_OVER   = 1;
  localparam int SB_FREE_L = 8;

  localparam int GB_MASTER = 31;

  // strobes from the control section to the datapath
  typedef struct packed {
    logic                push;
    logic [SAMPLE_W-1:0] pushData;
    logic                pop;
    logic                emit;
    logic                flush;
    logic                mono;
  } dpCmd_t;

endpackage

// File: rtl/dac_fifo_dp.sv
module dac_fifo_dp
  import dac_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCmd_t              cmd,
  output logic [CNT_W-1:0]    occupancy,
  output logic                empty,
  output logic                full,
  output logic [SAMPLE_W-1:0] outLeft,
  output logic [SAMPLE_W-1:0] outRight,
  output logic                outValid
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SAMPLE_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]    wrPtr, rdPtr;
  logic [CNT_W-1:0]    level;
  logic                slotRight;
  logic [SAMPLE_W-1:0] headData;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign occupancy = level;
  assign empty     = (level == '0);
  assign full      = (level == CNT_W'(DEPTH));
  assign headData  = store[rdPtr];

  always_ff @(posedge clk) begin
    if (cmd.push) store[wrPtr] <= cmd.pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (cmd.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (cmd.push) wrPtr <= nextPtr(wrPtr);
      if (cmd.pop)  rdPtr <= nextPtr(rdPtr);
      case ({cmd.push, cmd.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLeft   <= '0;
      outRight  <= '0;
      outValid  <= 1'b0;
      slotRight <= 1'b0;
    end else begin
      outValid <= cmd.emit;
      if (cmd.flush) begin
        slotRight <= 1'b0;
      end else if (cmd.emit) begin
        if (!cmd.pop) begin
          outLeft  <= '0;
          outRight <= '0;
        end else if (cmd.mono) begin
          outLeft  <= headData;
          outRight <= headData;
        end else if (slotRight) begin
          outRight  <= headData;
          slotRight <= 1'b0;
        end else begin
          outLeft   <= headData;
          slotRight <= 1'b1;
        end
      end
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    level <= CNT_W'(DEPTH));
  assert_push_not_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.push |-> !full);
  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.pop |-> !empty);
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.flush |=> (level == '0));
  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rstN)
    cmd.emit |=> outValid);

endmodule

// File: rtl/dac_fifo_ctrl.sv
module dac_fifo_ctrl
  import dac_fifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int ADDR_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  input  logic             sampleStrobe,
  input  logic [CNT_W-1:0] occupancy,
  input  logic             empty,
  input  logic             full,
  output dpCmd_t           cmd,
  output logic             dmaReq
);

  localparam int IW = ADDR_W - 2;

  logic [IW-1:0]    wordIdx;
  logic             selEnable, selCtrl, selStatus, selTx, selCount;
  logic             masterEn, runEn, dmaEn, wide24, monoEn;
  logic [2:0]       rateSel;
  logic [3:0]       trigLvl;
  logic             underFlag, overFlag;
  logic [REG_W-1:0] sampleCnt;
  logic [CNT_W-1:0] freeCnt;
  logic             flushReq, pushReq, runActive, popNow, emitNow;

  assign wordIdx   = busAddr[ADDR_W-1:2];
  assign selEnable = busWe && (wordIdx == IW'(IDX_ENABLE));
  assign selCtrl   = busWe && (wordIdx == IW'(IDX_CTRL));
  assign selStatus = busWe && (wordIdx == IW'(IDX_STATUS));
  assign selTx     = busWe && (wordIdx == IW'(IDX_TXDATA));
  assign selCount  = busWe && (wordIdx == IW'(IDX_COUNT));

  assign freeCnt   = CNT_W'(DEPTH) - occupancy;
  assign flushReq  = selCtrl && busWdata[CB_FLUSH];
  assign pushReq   = selTx && !full;
  assign runActive = masterEn && runEn;
  assign emitNow   = runActive && sampleStrobe && !flushReq;
  assign popNow    = emitNow && !empty;

  assign dmaReq = dmaEn && (8'(freeCnt) > {4'b0000, trigLvl});

  always_comb begin
    cmd.push     = pushReq;
    cmd.pushData = wide24 ? busWdata[SAMPLE_W-1:0] : {busWdata[15:0], 8'h00};
    cmd.pop      = popNow;
    cmd.emit     = emitNow;
    cmd.flush    = flushReq;
    cmd.mono     = monoEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      masterEn  <= 1'b0;
      runEn     <= 1'b0;
      dmaEn     <= 1'b0;
      wide24    <= 1'b0;
      monoEn    <= 1'b0;
      rateSel   <= '0;
      trigLvl   <= '0;
      underFlag <= 1'b0;
      overFlag  <= 1'b0;
      sampleCnt <= '0;
    end else begin
      if (selEnable) masterEn <= busWdata[GB_MASTER];
      if (selCtrl) begin
        runEn   <= busWdata[CB_RUN];
        dmaEn   <= busWdata[CB_DMAEN];
        wide24  <= busWdata[CB_WIDE];
        monoEn  <= busWdata[CB_MONO];
        trigLvl <= busWdata[CB_TRIG_L +: 4];
        rateSel <= busWdata[CB_RATE_L +: 3];
      end
      if (selStatus && busWdata[SB_UNDER]) underFlag <= 1'b0;
      if (selStatus && busWdata[SB_OVER])  overFlag  <= 1'b0;
      if (emitNow && empty)                underFlag <= 1'b1;
      if (selTx && full)                   overFlag  <= 1'b1;
      if (selCount)    sampleCnt <= busWdata;
      else if (popNow) sampleCnt <= sampleCnt + 1'b1;
    end
  end

  always_comb begin
    busRdata = '0;
    case (wordIdx)
      IW'(IDX_ENABLE): busRdata[GB_MASTER] = masterEn;
      IW'(IDX_CTRL): begin
        busRdata[CB_RATE_L +: 3] = rateSel;
        busRdata[CB_TRIG_L +: 4] = trigLvl;
        busRdata[CB_MONO]        = monoEn;
        busRdata[CB_WIDE]        = wide24;
        busRdata[CB_DMAEN]       = dmaEn;
        busRdata[CB_RUN]         = runEn;
      end
      IW'(IDX_STATUS): begin
        busRdata[SB_FREE_L +: 7] = 7'(freeCnt);
        busRdata[SB_OVER]        = overFlag;
        busRdata[SB_UNDER]       = underFlag;
      end
      IW'(IDX_COUNT): busRdata = sampleCnt;
      default: busRdata = '0;
    endcase
  end

  assert_full_no_request_R4: assert property (@(posedge clk) disable iff (!rstN)
    (occupancy == CNT_W'(DEPTH)) |-> !dmaReq);
  assert_halt_no_drain_R5: assert property (@(posedge clk) disable iff (!rstN)
    !masterEn |-> !cmd.pop && !cmd.emit);
  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && runActive && empty && !flushReq) |=> underFlag);
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    (popNow && !selCount) |=> (sampleCnt == $past(sampleCnt) + 32'd1));

endmodule

// File: rtl/dac_tx_fifo.sv
module dac_tx_fifo
  import dac_fifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              sampleStrobe,
  output logic              dmaReq,
  output logic [23:0]       outLeft,
  output logic [23:0]       outRight,
  output logic              outValid
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  dpCmd_t           cmd;
  logic [CNT_W-1:0] occupancy;
  logic             empty, full;

  dac_fifo_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sampleStrobe(sampleStrobe),
    .occupancy(occupancy), .empty(empty), .full(full), .cmd(cmd),
    .dmaReq(dmaReq)
  );

  dac_fifo_dp #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .occupancy(occupancy),
    .empty(empty), .full(full), .outLeft(outLeft), .outRight(outRight),
    .outValid(outValid)
  );

endmodule

// File: tb/dac_tx_fifo_bench.sv
module dac_tx_fifo_bench;

  localparam int DEPTH = 8;
  localparam logic [4:0] A_EN = 5'h00, A_CTL = 5'h04, A_ST = 5'h08,
                         A_TX = 5'h0C, A_CNT = 5'h10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sampleStrobe = 1'b0;
  logic        dmaReq, outValid;
  logic [23:0] outLeft, outRight;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dac_tx_fifo #(.DEPTH(DEPTH), .ADDR_W(5)) u_dac_tx_fifo (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sampleStrobe(sampleStrobe),
    .dmaReq(dmaReq), .outLeft(outLeft), .outRight(outRight),
    .outValid(outValid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic strobe();
    @(negedge clk);
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [23:0] expL, expR;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_EN, v);  chk("R1 enable", v, 0);
    rd(A_CTL, v); chk("R1 ctrl", v, 0);
    rd(A_ST, v);  chk("R1 status", v, DEPTH << 8);
    rd(A_CNT, v); chk("R1 counter", v, 0);
    chk("R1 outputs", {dmaReq, outValid, outLeft, outRight}, 0);

    // R11 rate code readback
    wr(A_CTL, 32'hA000_0000);
    rd(A_CTL, v); chk("R11 rate readback", v, 32'hA000_0000);

    // R4 / R3 sweep of fill level against trigger level
    for (int fill = 0; fill <= DEPTH; fill++) begin
      wr(A_CTL, 32'h1);
      for (int k = 0; k < fill; k++) wr(A_TX, k);
      rd(A_ST, v); chk("R3 free count", (v >> 8) & 32'h7F, DEPTH - fill);
      for (int t = 0; t < 16; t++) begin
        wr(A_CTL, (t << 8) | 32'h10);
        chk("R4 request vs trigger", dmaReq, ((DEPTH - fill) > t) ? 1 : 0);
      end
      wr(A_CTL, 32'h0);
      chk("R4 request gated", dmaReq, 0);
    end

    // R3 overflow when full
    wr(A_TX, 32'h55);
    rd(A_ST, v); chk("R3 overflow flag", v & 32'h3, 32'h2);
    chk("R3 free stays zero", (v >> 8) & 32'h7F, 0);

    // R8 write-one-to-clear
    wr(A_ST, 32'h0);
    rd(A_ST, v); chk("R8 zero write keeps flag", v & 32'h3, 32'h2);
    wr(A_ST, 32'h2);
    rd(A_ST, v); chk("R8 one write clears flag", v & 32'h3, 32'h0);

    // R9 flush: free back to depth, flush bit reads zero
    wr(A_CTL, 32'h15);
    rd(A_ST, v); chk("R9 flush empties", (v >> 8) & 32'h7F, DEPTH);
    rd(A_CTL, v); chk("R9 flush bit reads zero", v & 32'h1, 0);

    // R2 / R6 mono 16-bit
    wr(A_EN, 32'h8000_0000);
    wr(A_CTL, 32'h45);
    wr(A_TX, 32'hABCD_1234);
    strobe();
    chk("R12 valid after strobe", outValid, 1);
    chk("R2 R6 mono 16-bit left", outLeft, 24'h123400);
    chk("R6 mono 16-bit right", outRight, 24'h123400);
    @(negedge clk);
    chk("R12 valid single cycle", outValid, 0);

    // R2 mono 24-bit
    wr(A_CTL, 32'h65);
    wr(A_TX, 32'hFF87_6543);
    strobe();
    chk("R2 24-bit both slots", {8'h0, outLeft}, 32'h876543);
    chk("R2 24-bit right", {8'h0, outRight}, 32'h876543);

    // R10 counter preset, R3 order, R6 stereo alternation
    wr(A_CNT, 32'd100);
    wr(A_CTL, 32'h25);
    for (int k = 1; k <= 6; k++) wr(A_TX, k * 32'h111);
    expL = outLeft; expR = outRight;
    for (int k = 0; k < 6; k++) begin
      strobe();
      if (k % 2 == 0) expL = 24'((k + 1) * 32'h111);
      else            expR = 24'((k + 1) * 32'h111);
      chk("R6 stereo left slot", {8'h0, outLeft}, {8'h0, expL});
      chk("R3 R6 stereo right slot", {8'h0, outRight}, {8'h0, expR});
    end
    rd(A_CNT, v); chk("R10 counter after six", v, 106);

    // R9 slot returns to left after flush
    wr(A_TX, 32'h777);
    strobe();
    chk("R9 pre-flush left", {8'h0, outLeft}, 32'h777);
    wr(A_CTL, 32'h25);
    wr(A_TX, 32'h999);
    strobe();
    chk("R9 slot reset to left", {8'h0, outLeft}, 32'h999);
    chk("R9 right untouched", {8'h0, outRight}, {8'h0, expR});

    // R7 underrun
    rd(A_CNT, v);
    expL = 24'(v);
    strobe();
    chk("R7 underrun valid", outValid, 1);
    chk("R7 underrun zero outputs", {8'h0, outLeft | outRight}, 0);
    rd(A_ST, v); chk("R7 underrun flag", v & 32'h3, 32'h1);
    rd(A_CNT, v); chk("R7 counter unchanged", v[23:0], expL);
    wr(A_TX, 32'h123);
    strobe();
    rd(A_ST, v); chk("R7 flag sticky", v & 32'h1, 32'h1);
    wr(A_ST, 32'h1);
    rd(A_ST, v); chk("R8 underrun cleared", v & 32'h1, 0);

    // R5 master enable clear stops draining
    wr(A_EN, 32'h0);
    wr(A_TX, 32'h321);
    strobe();
    chk("R5 no valid while disabled", outValid, 0);
    rd(A_ST, v); chk("R5 entry kept", (v >> 8) & 32'h7F, DEPTH - 1);
    // R5 run bit clear stops draining
    wr(A_EN, 32'h8000_0000);
    wr(A_CTL, 32'h20);
    strobe();
    chk("R5 no valid without run", outValid, 0);
    rd(A_ST, v); chk("R5 entry kept run off", (v >> 8) & 32'h7F, DEPTH - 1);

    // R11 writing zero to control
    wr(A_CTL, 32'h34);
    chk("R11 request before stop", dmaReq, 1);
    wr(A_CTL, 32'h0);
    chk("R11 request dropped", dmaReq, 0);
    strobe();
    chk("R11 no drain after stop", outValid, 0);
    rd(A_ST, v); chk("R11 entry kept", (v >> 8) & 32'h7F, DEPTH - 1);
    rd(A_CNT, v); chk("R10 counter one more", v[23:0], expL + 24'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule